// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the data side of a small 8-bit processor. Six storage and compute elements share one internal bus: an accumulator, an ALU whose first input is the accumulator and whose second input is a B operand register, a program counter, a 16-entry RAM addressed through a memory address register, and an instruction register. In each clock step an external control unit raises drive lines that choose which element places its value on the bus and load lines that choose which elements capture that value at the clock edge. Every operation is therefore a sequence of single transfers, such as "program counter to address register" or "ALU result to accumulator".

The bus is a priority multiplexer rather than a set of tri-state buffers. When several drive lines are high, an error output is raised and the source with the lowest drive index wins. With no driver the bus reads zero. The control side receives the ALU zero flag, the instruction opcode and a copy of the bus. A separate write port lets a loader place bytes in the RAM.

Top module: `accbus_datapath`

## Requirements
- R1: While `rst` is high at a rising clock edge, the accumulator, B register, program counter, address register and instruction register become 0x00 and no RAM write takes place.
- R2: With all `drive_sel` bits low, `bus_obs` is 0x00.
- R3: With exactly one `drive_sel` bit set, `bus_obs` equals that source (bit 0 program counter, 1 RAM cell at the address register's low 4 bits, 2 instruction register, 3 accumulator, 4 B register, 5 ALU result), and each destination whose `load_sel` bit is set (bit 0 program counter, 1 address register, 2 RAM, 3 instruction register, 4 accumulator, 5 B register) holds that bus value after the edge.
- R4: With two or more `drive_sel` bits set, `bus_conflict` is 1 and the bus carries the set source with the lowest index; otherwise `bus_conflict` is 0.
- R5: The ALU computes accumulator+B for `alu_op` 00, accumulator-B for 01, bitwise AND for 10 and bitwise OR for 11, all modulo 256.
- R6: `zero_flag` is 1 exactly when the current ALU result is 0x00.
- R7: A program counter load from the bus takes precedence over `pc_inc`; with `pc_inc` alone the counter adds one and wraps from 0xFF to 0x00.
- R8: A RAM store writes the bus value into the cell selected by the low 4 bits of the address register, and the RAM source reads that same cell.
- R9: `opcode` shows the upper 4 bits of the instruction register.
- R10: `prog_we` writes `prog_data` into cell `prog_addr` unless a bus store to RAM happens in the same step, in which case only the bus store takes place.
- R11: A destination whose load bit is low keeps its value; the program counter also keeps it when `pc_inc` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| drive_sel | input | 6 | One drive line per bus source |
| load_sel | input | 6 | One load line per destination |
| alu_op | input | 2 | ALU function select |
| pc_inc | input | 1 | Program counter increment |
| prog_we | input | 1 | Loader write enable for RAM |
| prog_addr | input | 4 | Loader write address |
| prog_data | input | 8 | Loader write data |
| bus_obs | output | 8 | Current bus value |
| bus_conflict | output | 1 | More than one drive line is high |
| zero_flag | output | 1 | ALU result is zero |
| opcode | output | 4 | Upper nibble of the instruction register |

## Verification
The assertions watch, on every cycle, the reset clearing, the idle bus, the program counter winning a drive conflict, the capture of the bus by the accumulator, address register and instruction register, the counter's load-over-increment rule, the zero flag against a lone ALU drive, and the accumulator holding when not loaded. The RAM addressing, the precedence of a bus store over the loader port, the four ALU functions with concrete operands and the counter wrap from 0xFF need ordered scenarios, so only the bench's directed sequences and its reference model running beside random control words show them.

// File: rtl/accbus_datapath.sv
module accbus_datapath #(
  parameter int W  = 8,
  parameter int AW = 4,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [5:0]    drive_sel,
  input  logic [5:0]    load_sel,
  input  logic [1:0]    alu_op,
  input  logic          pc_inc,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [W-1:0]  prog_data,
  output logic [W-1:0]  bus_obs,
  output logic          bus_conflict,
  output logic          zero_flag,
  output logic [OW-1:0] opcode
);
  localparam int DEPTH = 1 << AW;
  localparam int NSRC  = 6;
  localparam int S_PC = 0, S_RAM = 1, S_IR = 2, S_ACC = 3, S_B = 4, S_ALU = 5;
  localparam int L_PC = 0, L_MAR = 1, L_RAM = 2, L_IR = 3, L_ACC = 4, L_B = 5;

  logic [W-1:0] acc, breg, pc, mar, ir, alu_y, bus;
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] src [NSRC];

  always_comb begin
    case (alu_op)
      2'b00:   alu_y = acc + breg;
      2'b01:   alu_y = acc - breg;
      2'b10:   alu_y = acc & breg;
      default: alu_y = acc | breg;
    endcase
  end

  assign src[S_PC]  = pc;
  assign src[S_RAM] = mem[mar[AW-1:0]];
  assign src[S_IR]  = ir;
  assign src[S_ACC] = acc;
  assign src[S_B]   = breg;
  assign src[S_ALU] = alu_y;

  always_comb begin
    bus = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (drive_sel[i]) bus = src[i];
  end

  assign bus_obs      = bus;
  assign bus_conflict = |(drive_sel & (drive_sel - 6'd1));
  assign zero_flag    = (alu_y == '0);
  assign opcode       = ir[W-1 -: OW];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      breg <= '0;
      pc   <= '0;
      mar  <= '0;
      ir   <= '0;
    end else begin
      if (load_sel[L_ACC]) acc  <= bus;
      if (load_sel[L_B])   breg <= bus;
      if (load_sel[L_MAR]) mar  <= bus;
      if (load_sel[L_IR])  ir   <= bus;
      if (load_sel[L_PC])  pc   <= bus;
      else if (pc_inc)     pc   <= pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (load_sel[L_RAM]) mem[mar[AW-1:0]] <= bus;
      else if (prog_we)    mem[prog_addr]   <= prog_data;
    end
  end
endmodule

// File: rtl/accbus_datapath_chk.sv
module accbus_datapath_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] drive_sel,
  input logic [5:0] load_sel,
  input logic       pc_inc,
  input logic [7:0] bus_obs,
  input logic       bus_conflict,
  input logic       zero_flag,
  input logic [3:0] opcode,
  input logic [7:0] acc,
  input logic [7:0] breg,
  input logic [7:0] pc,
  input logic [7:0] mar,
  input logic [7:0] ir
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc == 8'h00 && breg == 8'h00 && pc == 8'h00 && mar == 8'h00 && ir == 8'h00));

  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (rst)
    drive_sel == 6'b0 |-> bus_obs == 8'h00);

  assert_acc_capture_R3: assert property (@(posedge clk) disable iff (rst)
    load_sel[4] |=> acc == $past(bus_obs));

  assert_mar_capture_R3: assert property (@(posedge clk) disable iff (rst)
    load_sel[1] |=> mar == $past(bus_obs));

  assert_pc_wins_R4: assert property (@(posedge clk) disable iff (rst)
    drive_sel[0] |-> bus_obs == pc);

  assert_single_ok_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drive_sel) |-> !bus_conflict);

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
    drive_sel == 6'b100000 |-> zero_flag == (bus_obs == 8'h00));

  assert_pc_load_R7: assert property (@(posedge clk) disable iff (rst)
    load_sel[0] |=> pc == $past(bus_obs));

  assert_pc_inc_R7: assert property (@(posedge clk) disable iff (rst)
    (!load_sel[0] && pc_inc) |=> pc == $past(pc) + 8'd1);

  assert_opcode_R9: assert property (@(posedge clk) disable iff (rst)
    load_sel[3] |=> opcode == $past(bus_obs[7:4]));

  assert_acc_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !load_sel[4] |=> acc == $past(acc));
endmodule

bind accbus_datapath accbus_datapath_chk chk (
  .clk(clk), .rst(rst), .drive_sel(drive_sel), .load_sel(load_sel),
  .pc_inc(pc_inc), .bus_obs(bus_obs), .bus_conflict(bus_conflict),
  .zero_flag(zero_flag), .opcode(opcode), .acc(acc), .breg(breg),
  .pc(pc), .mar(mar), .ir(ir)
);

// File: tb/accbus_datapath_test.sv
module accbus_datapath_test;
  localparam int CLK_P = 10;
  localparam logic [5:0] D_PC = 6'd1, D_RAM = 6'd2, D_IR = 6'd4, D_ACC = 6'd8, D_B = 6'd16, D_ALU = 6'd32;
  localparam logic [5:0] L_PC = 6'd1, L_MAR = 6'd2, L_RAM = 6'd4, L_IR = 6'd8, L_ACC = 6'd16, L_B = 6'd32;

  logic clk = 0, rst = 1;
  logic [5:0] drive_sel = 0, load_sel = 0;
  logic [1:0] alu_op = 0;
  logic pc_inc = 0, prog_we = 0;
  logic [3:0] prog_addr = 0;
  logic [7:0] prog_data = 0;
  logic [7:0] bus_obs;
  logic bus_conflict, zero_flag;
  logic [3:0] opcode;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_acc, m_b, m_pc, m_mar, m_ir;
  logic [7:0] m_ram [16];

  accbus_datapath uut (
    .clk(clk), .rst(rst), .drive_sel(drive_sel), .load_sel(load_sel), .alu_op(alu_op),
    .pc_inc(pc_inc), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .bus_obs(bus_obs), .bus_conflict(bus_conflict), .zero_flag(zero_flag), .opcode(opcode)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] f_alu(input logic [1:0] op);
    case (op)
      2'b00:   return m_acc + m_b;
      2'b01:   return m_acc - m_b;
      2'b10:   return m_acc & m_b;
      default: return m_acc | m_b;
    endcase
  endfunction

  function automatic logic [7:0] f_bus(input logic [5:0] d, input logic [1:0] op);
    if (d[0]) return m_pc;
    if (d[1]) return m_ram[m_mar[3:0]];
    if (d[2]) return m_ir;
    if (d[3]) return m_acc;
    if (d[4]) return m_b;
    if (d[5]) return f_alu(op);
    return 8'h00;
  endfunction

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic step(input logic [5:0] d, input logic [5:0] l, input logic [1:0] op,
                      input logic inc, input logic we, input logic [3:0] pa,
                      input logic [7:0] pd, input string tag);
    logic [7:0] b;
    drive_sel = d; load_sel = l; alu_op = op; pc_inc = inc;
    prog_we = we; prog_addr = pa; prog_data = pd;
    #(CLK_P/4);
    b = f_bus(d, op);
    if (!rst) begin
      chk(bus_obs, b, {tag, " bus R3"});
      chk({7'b0, bus_conflict}, {7'b0, ($countones(d) > 1)}, {tag, " conflict R4"});
      chk({7'b0, zero_flag}, {7'b0, (f_alu(op) == 8'h00)}, {tag, " zero R6"});
      chk({4'b0, opcode}, {4'b0, m_ir[7:4]}, {tag, " opcode R9"});
    end
    @(posedge clk);
    if (rst) begin
      m_acc = 0; m_b = 0; m_pc = 0; m_mar = 0; m_ir = 0;
    end else begin
      if (l[2]) m_ram[m_mar[3:0]] = b;
      else if (we) m_ram[pa] = pd;
      if (l[0]) m_pc = b; else if (inc) m_pc = m_pc + 8'd1;
      if (l[1]) m_mar = b;
      if (l[3]) m_ir = b;
      if (l[4]) m_acc = b;
      if (l[5]) m_b = b;
    end
    @(negedge clk);
  endtask

  task automatic idle(input logic [5:0] d, input logic [5:0] l, input string tag);
    step(d, l, 2'b00, 1'b0, 1'b0, 4'd0, 8'd0, tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1badd00d));
    m_acc = 0; m_b = 0; m_pc = 0; m_mar = 0; m_ir = 0;
    for (int i = 0; i < 16; i++) m_ram[i] = 0;
    @(negedge clk);
    idle(0, 0, "reset");
    rst = 0;
    for (int i = 0; i < 16; i++)
      step(0, 0, 0, 0, 1, 4'(i), (i == 0) ? 8'd5 : (i == 1) ? 8'd10 : (i == 2) ? 8'd15 : 8'($urandom), "R10 load");

    idle(0, 0, "R2 idle");
    chk(bus_obs, 8'h00, "R2 no driver");
    idle(D_PC, L_MAR, "R3 pc to mar");
    step(D_RAM, L_B, 0, 1, 0, 0, 0, "R8 ram to b");
    step(D_ALU, L_ACC, 2'b00, 0, 0, 0, 0, "R5 add");
    idle(D_PC, L_MAR, "R3 pc to mar");
    step(D_RAM, L_B, 0, 1, 0, 0, 0, "R8 ram to b");
    step(D_ALU, L_ACC, 2'b00, 0, 0, 0, 0, "R5 add");
    idle(D_ACC, 0, "R5 sum");
    chk(bus_obs, 8'd15, "R5 accumulated 5+10");
    idle(D_PC, L_MAR, "R3 pc to mar");
    idle(D_RAM, L_B, "R8 ram to b");
    step(D_ALU, 0, 2'b01, 0, 0, 0, 0, "R6 sub");
    chk({7'b0, zero_flag}, 8'd1, "R6 zero after 15-15");
    step(D_ALU, L_ACC, 2'b01, 0, 0, 0, 0, "R5 sub");
    chk({7'b0, zero_flag}, 8'd0, "R6 nonzero 0-15");
    step(D_ALU, 0, 2'b01, 0, 0, 0, 0, "R5 sub");
    chk(bus_obs, 8'hF1, "R5 wrap 0-15");
    step(D_ALU, 0, 2'b10, 0, 0, 0, 0, "R5 and");
    step(D_ALU, 0, 2'b11, 0, 0, 0, 0, "R5 or");
    idle(D_PC | D_ACC, 0, "R4 conflict");
    chk(bus_obs, 8'd2, "R4 lowest index wins");
    idle(D_B | D_ALU | D_IR, 0, "R4 triple");

    step(D_ACC, L_PC, 0, 1, 0, 0, 0, "R7 load beats inc");
    idle(D_PC, 0, "R7 pc");
    chk(bus_obs, 8'h00, "R7 load over inc");
    step(D_ALU, L_PC, 2'b01, 0, 0, 0, 0, "R7 pc=F1");
    for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 0, 0, 0, "R7 inc");
    idle(D_PC, 0, "R7 wrap");
    chk(bus_obs, 8'h00, "R7 wrap FF to 00");

    step(0, 0, 0, 0, 1, 4'd2, 8'hA7, "R10 write");
    idle(D_RAM, L_IR, "R9 fetch");
    chk({4'b0, opcode}, 8'h0A, "R9 opcode nibble");
    step(D_B, L_RAM, 0, 0, 1, 4'd2, 8'h55, "R10 collide");
    idle(D_RAM, 0, "R10 bus store wins");
    chk(bus_obs, 8'd15, "R10 bus store wins");
    idle(D_IR, 0, "R11 hold");
    chk(bus_obs, 8'hA7, "R11 ir kept");

    idle(D_B, L_ACC | L_MAR | L_IR | L_PC, "R1 prefill");
    rst = 1;
    step(D_B, L_ACC, 0, 1, 1, 4'd0, 8'hEE, "R1 reset");
    rst = 0;
    idle(D_ACC, 0, "R1 acc"); chk(bus_obs, 8'h00, "R1 acc cleared");
    idle(D_B, 0, "R1 b");     chk(bus_obs, 8'h00, "R1 b cleared");
    idle(D_PC, 0, "R1 pc");   chk(bus_obs, 8'h00, "R1 pc cleared");
    idle(D_IR, 0, "R1 ir");   chk(bus_obs, 8'h00, "R1 ir cleared");
    idle(D_RAM, 0, "R1 mar"); chk(bus_obs, 8'd5, "R1 mar cleared and ram kept");

    for (int n = 0; n < 3000; n++) begin
      logic [5:0] d;
      int k = $urandom_range(0, 7);
      d = (k < 6) ? 6'(1 << k) : (k == 6) ? 6'd0 : 6'($urandom);
      step(d, 6'($urandom), 2'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
           4'($urandom), 8'($urandom), "R3 R8 R11 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule